// File: doc/BRIEF.md
# Hash Message Padding Unit

This unit sits between a word input queue and a 512-bit compression core. Message words of 32 bits arrive on a valid/ready interface and are packed into a 512-bit block register. A full block is released once the producer shows that more message follows. The producer may offer another word, or it may issue the final command. When the final command arrives, the unit trims the last word to the number of valid bits loaded beforehand. It then appends a single one bit and zero fill, and places the 64-bit count of message bits in the top two words of the closing block.

The count of message bits runs across every block of the message. It is cleared after the closing block has been taken, so the next message starts from zero. A configuration bit selects how the two halves of the length field are ordered: big-endian for SHA-1 (the reset choice) or little-endian for MD5. If the one bit and the length field do not both fit in the current block, the unit emits one extra block. That block holds only padding and the length. Every emitted block carries a marker that says whether it closes the message.

Top module: `hash_pad_unit`

## Requirements
- R1: After reset no block is offered (`blk_valid`=0, `blk_last`=0), `word_ready` is 1, and the length ordering is SHA-1.
- R2: Accepted words fill the block in arrival order, word i occupying `blk_data[32i+31:32i]`. A block of 16 words is offered with `blk_last`=0 only when a 17th word is offered or the final command arrives.
- R3: Let n be the valid count held when `go` is taken. If n is 1 to 31, the last word keeps bits [n-1:0], its bits above n are cleared, and bit n is set to 1. If n is 0, the last word is kept whole and the one bit is placed at bit 0 of the following word position.
- R4: Every bit between the one bit and bit 448 of the closing block is zero.
- R5: The length field holds the total count of valid message bits. That count is 32 per whole word, plus n for a partial last word, summed over all blocks of the message.
- R6: With `cfg_md5`=0 (SHA-1), bits [479:448] of the closing block hold length bits [63:32] and bits [511:480] hold length bits [31:0]. With `cfg_md5`=1 (MD5) the two halves swap. The selection is written with `cfg_we`.
- R7: If the one bit falls at block bit position 448 or higher, the unit emits two blocks. The first holds data, the one bit if it falls below 512, and zeros, with `blk_last`=0. The second holds zeros, the length in bits [511:448], and the one bit at bit 0 when the last word filled the first block, with `blk_last`=1. Otherwise a single block is emitted with `blk_last`=1.
- R8: While `blk_valid` is high and `blk_ready` is low, `blk_data` and `blk_last` hold steady. No word is accepted while a block is offered.
- R9: After the block with `blk_last`=1 is taken, the word position and bit count return to zero for the next message. A new valid count written between messages applies only to later messages.
- R10: A final command with no words yields one block with the one bit at bit 0 and a length of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the algorithm selection |
| cfg_md5 | input | 1 | 1 selects MD5 length ordering, 0 selects SHA-1 |
| nb_we | input | 1 | Write strobe for the last-word valid count |
| nb_val | input | 5 | Valid bits in the last word, 0 meaning all 32 |
| word_valid | input | 1 | A message word is offered |
| word_data | input | 32 | Message word |
| word_ready | output | 1 | Word accepted on this edge when `word_valid` is high |
| go | input | 1 | Final command: pad and close the message |
| blk_valid | output | 1 | A 512-bit block is offered |
| blk_data | output | 512 | Block contents |
| blk_last | output | 1 | The offered block closes the message |
| blk_ready | input | 1 | Downstream takes the block on this edge |

## Verification
The bench pushes the one bit to both sides of the 448-bit limit. At position 447 a single block is expected. At position 448, and at the exact 512-bit fill, a second block is expected. A unit with an off-by-one room test would give a block too many or too few, or would write the length over the marker. Partial last words are sent with their high bits set, so a unit that failed to clear them, or that put the one bit at the wrong position, shows at once in the data. A long message sent under irregular downstream stalls checks the bit count across blocks, the two length orderings, and that blocks hold steady. A message with no words and a repeat after a long one check that the count starts again from zero.

// File: rtl/hash_pad_unit.sv
module hash_pad_unit #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16,
  parameter int LEN_W     = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic                        cfg_md5,
  input  logic                        nb_we,
  input  logic [$clog2(WORD_W)-1:0]   nb_val,
  input  logic                        word_valid,
  input  logic [WORD_W-1:0]           word_data,
  output logic                        word_ready,
  input  logic                        go,
  output logic                        blk_valid,
  output logic [WORD_W*BLK_WORDS-1:0] blk_data,
  output logic                        blk_last,
  input  logic                        blk_ready
);
  localparam int BLK_W  = WORD_W * BLK_WORDS;
  localparam int NB_W   = $clog2(WORD_W);
  localparam int IDX_W  = $clog2(BLK_WORDS + 1);
  localparam int POS_W  = $clog2(BLK_W + 1);
  localparam int LEN_AT = BLK_W - LEN_W;

  typedef enum logic [1:0] {S_FILL, S_OUT, S_FIN1, S_FIN2} st_t;

  st_t              st_q;
  logic [BLK_W-1:0] blk_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] bits_q, len_q;
  logic [NB_W-1:0]  nb_q;
  logic             md5_q, two_q, mark2_q;

  logic             part;
  logic [POS_W-1:0] pos;
  logic [LEN_W-1:0] len_go, lenfld;
  logic [BLK_W-1:0] padded;
  logic             full;

  assign full = (idx_q == IDX_W'(BLK_WORDS));
  assign part = (idx_q != '0) && (nb_q != '0);
  assign pos  = part ? POS_W'(idx_q - 1'b1) * POS_W'(WORD_W) + POS_W'(nb_q)
                     : POS_W'(idx_q) * POS_W'(WORD_W);
  assign len_go = part ? bits_q - LEN_W'(WORD_W - int'(nb_q)) : bits_q;

  always_comb begin
    for (int i = 0; i < BLK_W; i++)
      padded[i] = (POS_W'(i) < pos) ? blk_q[i] : (POS_W'(i) == pos);
  end

  assign lenfld = md5_q ? len_q : {len_q[WORD_W-1:0], len_q[LEN_W-1:WORD_W]};

  assign word_ready = (st_q == S_FILL) && !full && !go;
  assign blk_valid  = (st_q != S_FILL);
  assign blk_last   = (st_q == S_FIN2) || (st_q == S_FIN1 && !two_q);
  assign blk_data   = (st_q == S_FIN2) ? {lenfld, {(LEN_AT-1){1'b0}}, mark2_q}
                    : (st_q == S_FIN1 && !two_q) ? {lenfld, blk_q[LEN_AT-1:0]}
                    : blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md5_q <= 1'b0;
      nb_q  <= '0;
    end else begin
      if (cfg_we) md5_q <= cfg_md5;
      if (nb_we)  nb_q  <= nb_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_FILL;
      blk_q   <= '0;
      idx_q   <= '0;
      bits_q  <= '0;
      len_q   <= '0;
      two_q   <= 1'b0;
      mark2_q <= 1'b0;
    end else begin
      case (st_q)
        S_FILL: begin
          if (go) begin
            blk_q   <= padded;
            len_q   <= len_go;
            two_q   <= (pos >= POS_W'(LEN_AT));
            mark2_q <= (pos == POS_W'(BLK_W));
            st_q    <= S_FIN1;
          end else if (word_valid) begin
            if (full) begin
              st_q <= S_OUT;
            end else begin
              blk_q[int'(idx_q)*WORD_W +: WORD_W] <= word_data;
              idx_q  <= idx_q + 1'b1;
              bits_q <= bits_q + LEN_W'(WORD_W);
            end
          end
        end
        S_OUT: if (blk_ready) begin
          idx_q <= '0;
          st_q  <= S_FILL;
        end
        S_FIN1: if (blk_ready) begin
          if (two_q) begin
            st_q <= S_FIN2;
          end else begin
            st_q   <= S_FILL;
            idx_q  <= '0;
            bits_q <= '0;
            blk_q  <= '0;
          end
        end
        default: if (blk_ready) begin
          st_q   <= S_FILL;
          idx_q  <= '0;
          bits_q <= '0;
          blk_q  <= '0;
        end
      endcase
    end
  end

  a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(BLK_WORDS));

  a_r8_hold_block: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_data) && $stable(blk_last));

  a_r8_no_word_while_block: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> !word_ready);

  a_r7_second_block_closes: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready && !blk_last && st_q == S_FIN1 |=> blk_valid && blk_last);

  a_r9_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready && blk_last |=> st_q == S_FILL && idx_q == '0 && bits_q == '0);

  a_r2_full_waits: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_FILL && full && !go && !word_valid |=> st_q == S_FILL && full);
endmodule

// File: tb/hash_pad_unit_tb.sv
module hash_pad_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         cfg_we = 0, cfg_md5 = 0, nb_we = 0;
  logic [4:0]   nb_val = 0;
  logic         word_valid = 0;
  logic [31:0]  word_data = 0;
  logic         word_ready;
  logic         go = 0;
  logic         blk_valid, blk_last;
  logic [511:0] blk_data;
  logic         blk_ready = 1;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit exp_s [0:2047];
  int exp_blocks;
  logic [31:0] msg [0:63];
  bit cur_md5 = 0;

  hash_pad_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_md5(cfg_md5),
    .nb_we(nb_we), .nb_val(nb_val), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .go(go),
    .blk_valid(blk_valid), .blk_data(blk_data), .blk_last(blk_last),
    .blk_ready(blk_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic fill_msg(int seed);
    for (int j = 0; j < 64; j++)
      msg[j] = (32'h9E3779B9 * (j + seed)) ^ 32'hF000_0000 ^ (32'(seed) << 8);
  endtask

  task automatic build_expect(int n, int nb);
    bit part;
    logic [63:0] len;
    int p, base;
    for (int i = 0; i < 2048; i++) exp_s[i] = 0;
    part = (n > 0) && (nb != 0);
    len  = 64'(32 * n - (part ? 32 - nb : 0));
    p    = part ? 32 * (n - 1) + nb : 32 * n;
    for (int j = 0; j < n; j++)
      for (int k = 0; k < 32; k++)
        if (32 * j + k < p) exp_s[32*j+k] = msg[j][k];
    exp_s[p] = 1;
    exp_blocks = (p + 64) / 512 + 1;
    base = 512 * (exp_blocks - 1);
    for (int k = 0; k < 32; k++) begin
      exp_s[base+448+k] = cur_md5 ? len[k]    : len[32+k];
      exp_s[base+480+k] = cur_md5 ? len[32+k] : len[k];
    end
  endtask

  task automatic run_msg(int n, int nb, bit set_cfg, bit md5, bit stall, string req);
    int got = 0;
    if (set_cfg) begin
      @(negedge clk); cfg_we = 1; cfg_md5 = md5;
      @(negedge clk); cfg_we = 0;
      cur_md5 = md5;
    end
    @(negedge clk); nb_we = 1; nb_val = 5'(nb);
    @(negedge clk); nb_we = 0;
    build_expect(n, nb);
    fork
      begin
        for (int j = 0; j < n; j++) begin
          @(negedge clk); word_valid = 1; word_data = msg[j];
          #1;
          while (!word_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk); word_valid = 0; go = 1;
        @(negedge clk); go = 0;
      end
      begin
        bit fin = 0, waiting = 0;
        logic [511:0] prev = '0;
        logic [511:0] e;
        int cyc = 0;
        while (!fin) begin
          @(negedge clk);
          cyc++;
          blk_ready = stall ? (cyc % 3 == 0) : 1'b1;
          #1;
          if (blk_valid) begin
            if (word_ready) check(0, "R8", "word_ready while block offered", 1, 0);
            if (waiting) check(blk_data == prev, "R8", "block held while stalled",
                               blk_data[63:0], prev[63:0]);
            if (blk_ready) begin
              for (int k = 0; k < 512; k++) e[k] = (got < 4) ? exp_s[512*got+k] : 1'b0;
              for (int w = 0; w < 16; w++)
                if (blk_data[32*w +: 32] != e[32*w +: 32])
                  check(0, req, $sformatf("block %0d word %0d", got, w),
                        64'(blk_data[32*w +: 32]), 64'(e[32*w +: 32]));
              check(blk_data == e, req, $sformatf("block %0d contents", got),
                    blk_data[511:448], e[511:448]);
              check(blk_last == (got == exp_blocks - 1), "R7",
                    $sformatf("last marker block %0d", got), 64'(blk_last),
                    64'(got == exp_blocks - 1));
              got++;
              if (blk_last || got > 4) fin = 1;
              waiting = 0;
            end else begin
              waiting = 1;
              prev = blk_data;
            end
          end
        end
        blk_ready = 1;
      end
    join
    check(got == exp_blocks, "R7", "block count", 64'(got), 64'(exp_blocks));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(blk_valid == 0, "R1", "blk_valid after reset", 64'(blk_valid), 0);
    check(blk_last == 0, "R1", "blk_last after reset", 64'(blk_last), 0);
    check(word_ready == 1, "R1", "word_ready after reset", 64'(word_ready), 1);

    fill_msg(1);
    run_msg(0, 0, 0, 0, 0, "R10 R1");
    fill_msg(2);
    run_msg(3, 0, 0, 0, 0, "R2 R4 R5");
    fill_msg(3);
    run_msg(5, 5, 0, 0, 0, "R3 R4");
    fill_msg(4);
    run_msg(7, 12, 1, 1, 0, "R6 MD5");
    fill_msg(5);
    run_msg(14, 31, 1, 0, 0, "R7 one-block edge");
    fill_msg(6);
    run_msg(14, 0, 0, 0, 0, "R7 two-block edge");
    fill_msg(7);
    run_msg(16, 0, 0, 0, 1, "R7 R2 exact fill");
    fill_msg(8);
    run_msg(40, 17, 1, 1, 1, "R5 R8 MD5 multi-block");
    fill_msg(9);
    run_msg(40, 17, 1, 0, 1, "R5 R6 R8 SHA-1 multi-block");
    fill_msg(10);
    run_msg(2, 9, 0, 0, 0, "R9 restart");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule